// File: doc/BRIEF.md
# Truncated Fractional Signed Array Multiplier

This block multiplies two W-bit two's complement fractions and returns a product of the same word length. In each operand the most significant bit is the sign and carries weight -1. The other bits carry weights 1/2, 1/4 and so on, so each operand lies between -1 and 1 - 2^-(W-1). The multiplier is fully parallel. It builds the product as a chain of partial-product rows in Horner order. Each row adds the multiplicand to the running sum when its multiplier bit is set, and then halves the sum. Every sum is sign-extended, so negative values add correctly.

The row for the multiplier sign bit has negative weight. That row adds the bitwise inverse of the multiplicand and injects a carry of one at the least significant position. Internal sums keep the full 2W-1 significant bits of the product. The output keeps only the upper W of them, and the discarded low part is simply dropped. The pair -1 times -1 gives +1, which the W-bit fraction cannot represent. For that pair the output saturates to the largest positive code and raises an overflow flag.

A new operand pair may be presented on any cycle. The result, its overflow flag and the output valid are registered once, so each result appears one cycle after its inputs.

Top module: `smul_trunc_frac`

## Requirements
- R1: A synchronous active-high reset drives out_valid, x_out and ovf_out to zero on the next rising edge.
- R2: out_valid is high in the cycle after a cycle with in_valid high. It is low in the cycle after a cycle with in_valid low.
- R3: Read a_in and b_in as signed integers a and b, with the msb as the sign bit. For every pair other than a = b = -2^(W-1), the x_out captured one cycle later equals floor(a*b / 2^(W-1)) as a W-bit two's complement code.
- R4: The dropped low-order bits are never rounded. A product with a magnitude below one output lsb gives 0 when it is positive and all ones (-1 lsb) when it is negative. For example, a = 1 and b = -1 give x_out = all ones.
- R5: When a = b = -2^(W-1), the registered result is x_out = 2^(W-1)-1 (msb 0, all other bits 1) with ovf_out = 1. For every other accepted pair, ovf_out = 0.
- R6: When b has its sign bit set, the product includes the subtracted row. For b = -2^(W-1) and a other than -2^(W-1), x_out = -a. For a = -2^(W-1) and b = 2^(W-1)-1, x_out = -2^(W-1)+1.
- R7: x_out and ovf_out keep their values through every cycle with in_valid low, whatever a_in and b_in do.
- R8: The arithmetic of R3 holds for any W of at least 3. It is shown exhaustively at W = 6 and on random pairs at W = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_in | input | W | Multiplicand, signed fraction |
| b_in | input | W | Multiplier, signed fraction |
| out_valid | output | 1 | Registered result valid |
| x_out | output | W | Upper W bits of the product, saturated |
| ovf_out | output | 1 | Result saturated because the product was +1 |

## Verification
The hardest situation to reach is the single operand pair that saturates. Only one of the 2^(2W) pairs produces it, so random operands alone would almost never hit it. Two sweeps cover it. The bench walks every pair exhaustively at W = 6, which includes the saturating pair. At W = 8 it forces that pair explicitly, next to random pairs and the neighbouring sign-row corners. The zero-crossing pairs for truncation are driven directly, so a rounding error would show as a one-lsb difference.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Width of the internal accumulator: full product (2W-1 bits) plus sign and guard.
  function automatic int acc_width(input int w);
    return 2 * w + 1;
  endfunction

  // Number of low-order product bits discarded by the truncation.
  function automatic int drop_bits(input int w);
    return w - 1;
  endfunction

  // Index of the lowest accumulator bit that must equal the sign in range.
  function automatic int range_top(input int w);
    return 2 * w - 2;
  endfunction
endpackage

// File: rtl/smul_row.sv
module smul_row #(
  parameter int W  = 8,
  parameter int AW = 17
) (
  input  logic [AW-1:0] acc_in,
  input  logic [W-1:0]  a_in,
  input  logic          bit_in,
  output logic [AW-1:0] acc_out
);
  // Multiplicand aligned to the msb weight of the running sum.
  function automatic logic [AW-1:0] align_a(input logic [W-1:0] a);
    logic [AW-1:0] ext;
    ext = {{(AW-W){a[W-1]}}, a};
    return ext << (W - 1);
  endfunction

  // Add then halve with sign replication (exact: low bit is always zero before shift
  // once enough rows have accumulated, and the guard keeps precision otherwise).
  function automatic logic [AW-1:0] add_halve(input logic [AW-1:0] s, input logic [AW-1:0] t);
    logic [AW-1:0] sum;
    sum = s + t;
    return {sum[AW-1], sum[AW-1:1]};
  endfunction

  logic [AW-1:0] addend;
  assign addend  = bit_in ? align_a(a_in) : '0;
  assign acc_out = add_halve(acc_in, addend);
endmodule

// File: rtl/smul_sign_row.sv
module smul_sign_row #(
  parameter int W  = 8,
  parameter int AW = 17
) (
  input  logic [AW-1:0] acc_in,
  input  logic [W-1:0]  a_in,
  input  logic          sign_bit,
  output logic [AW-1:0] prod_out
);
  function automatic logic [AW-1:0] align_a(input logic [W-1:0] a);
    logic [AW-1:0] ext;
    ext = {{(AW-W){a[W-1]}}, a};
    return ext << (W - 1);
  endfunction

  // Subtraction as inverted operand plus a carry injected at the lsb.
  function automatic logic [AW-1:0] sub_row(input logic [AW-1:0] s, input logic [AW-1:0] t,
                                            input logic en);
    logic [AW-1:0] inv;
    logic [AW-1:0] cin;
    inv = en ? ~t : '0;
    cin = {{(AW-1){1'b0}}, en};
    return s + inv + cin;
  endfunction

  assign prod_out = sub_row(acc_in, align_a(a_in), sign_bit);
endmodule

// File: rtl/smul_out_stage.sv
module smul_out_stage #(
  parameter int W  = 8,
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] prod_in,
  output logic          ovf_event,
  output logic [W-1:0]  x_next,
  output logic          out_valid,
  output logic [W-1:0]  x_out,
  output logic          ovf_out
);
  localparam int TOP = smul_pkg::range_top(W);
  localparam int LO  = smul_pkg::drop_bits(W);
  localparam int NCHK = AW - TOP;

  // The product is in range when every bit from TOP upward equals the sign.
  function automatic logic out_of_range(input logic [AW-1:0] p);
    logic [NCHK-1:0] hi;
    hi = p[AW-1:TOP];
    return !((hi == '0) || (hi == '1));
  endfunction

  function automatic logic [W-1:0] sat_code(input logic neg);
    return neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
  endfunction

  assign ovf_event = out_of_range(prod_in);
  assign x_next    = ovf_event ? sat_code(prod_in[AW-1]) : prod_in[TOP:LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      x_out     <= '0;
      ovf_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        x_out   <= x_next;
        ovf_out <= ovf_event;
      end
    end
  end
endmodule

// File: rtl/smul_trunc_frac.sv
module smul_trunc_frac #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         out_valid,
  output logic [W-1:0] x_out,
  output logic         ovf_out
);
  localparam int AW = smul_pkg::acc_width(W);

  logic [AW-1:0] acc_chain [W];
  logic [AW-1:0] full_prod;
  logic          ovf_event;
  logic [W-1:0]  x_next;

  assign acc_chain[0] = '0;

  // Horner chain: rows for b[0] .. b[W-2], each adding then halving.
  for (genvar i = 0; i < W - 1; i++) begin : g_row
    smul_row #(.W(W), .AW(AW)) row_i (
      .acc_in (acc_chain[i]),
      .a_in   (a_in),
      .bit_in (b_in[i]),
      .acc_out(acc_chain[i+1])
    );
  end

  smul_sign_row #(.W(W), .AW(AW)) sign_i (
    .acc_in  (acc_chain[W-1]),
    .a_in    (a_in),
    .sign_bit(b_in[W-1]),
    .prod_out(full_prod)
  );

  smul_out_stage #(.W(W), .AW(AW)) out_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .prod_in  (full_prod),
    .ovf_event(ovf_event),
    .x_next   (x_next),
    .out_valid(out_valid),
    .x_out    (x_out),
    .ovf_out  (ovf_out)
  );
endmodule

// File: rtl/smul_trunc_frac_chk.sv
module smul_trunc_frac_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         out_valid,
  input logic [W-1:0] x_out,
  input logic         ovf_out,
  input logic         ovf_event
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && x_out == '0 && !ovf_out));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  // R5
  sat_result_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_in == MINV && b_in == MINV) |=> (ovf_out && x_out == MAXV));

  // R5
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_event |-> (a_in == MINV && b_in == MINV));

  // R4
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a_in == '0 || b_in == '0)) |=> (x_out == '0 && !ovf_out));

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(x_out) && $stable(ovf_out)));
endmodule

bind smul_trunc_frac smul_trunc_frac_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .a_in     (a_in),
  .b_in     (b_in),
  .out_valid(out_valid),
  .x_out    (x_out),
  .ovf_out  (ovf_out),
  .ovf_event(ovf_event)
);

// File: tb/smul_trunc_frac_tb_top.sv
module smul_trunc_frac_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic       v8 = 1'b0, v6 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic [5:0] a6 = '0, b6 = '0;
  logic       ov8, ov6, of8, of6;
  logic [7:0] x8;
  logic [5:0] x6;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  smul_trunc_frac #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(v8), .a_in(a8), .b_in(b8),
    .out_valid(ov8), .x_out(x8), .ovf_out(of8));

  smul_trunc_frac #(.W(6)) dut_w6_i (
    .clk(clk), .rst(rst), .in_valid(v6), .a_in(a6), .b_in(b6),
    .out_valid(ov6), .x_out(x6), .ovf_out(of6));

  // Expected result: floor of the integer product by 2^(W-1), saturated at +1.
  function automatic int exp_x(input int a, input int b, input int w);
    longint p;
    longint q;
    p = longint'(a) * longint'(b);
    q = p >>> (w - 1);
    if (q > (64'sd1 <<< (w - 1)) - 1) q = (64'sd1 <<< (w - 1)) - 1;
    return int'(q);
  endfunction

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run8(input string req, input int a, input int b);
    int e;
    @(negedge clk);
    a8 = 8'(a); b8 = 8'(b); v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    e = exp_x(a, b, 8);
    check(req, sx(int'(x8), 8), e);
    check({req, " ovf"}, int'(of8), (a == -128 && b == -128) ? 1 : 0);
    check("R2 valid", int'(ov8), 1);
  endtask

  task automatic run6(input int a, input int b);
    @(negedge clk);
    a6 = 6'(a); b6 = 6'(b); v6 = 1'b1;
    @(negedge clk);
    v6 = 1'b0;
    check("R8 w6", sx(int'(x6), 6), exp_x(a, b, 6));
    check("R5 w6 ovf", int'(of6), (a == -32 && b == -32) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", int'(ov8), 0);
    check("R1 x", int'(x8), 0);
    check("R1 ovf", int'(of8), 0);

    // R3 basic patterns
    run8("R3", 64, 64);
    run8("R3", 127, 127);
    run8("R3", -37, 91);
    run8("R3", 5, 0);
    // R4 truncation toward minus infinity
    run8("R4", 1, -1);
    run8("R4", 1, 1);
    run8("R4", -3, 5);
    // R6 sign row
    run8("R6", 77, -128);
    run8("R6", -128, 127);
    run8("R6", -1, -128);
    // R5 saturation
    run8("R5", -128, -128);

    // R7 hold while in_valid low
    @(negedge clk);
    a8 = 8'd3; b8 = 8'd3;
    @(negedge clk);
    check("R7 x hold", sx(int'(x8), 8), 127);
    check("R7 ovf hold", int'(of8), 1);
    check("R2 valid low", int'(ov8), 0);

    // R1 reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 x after reset", int'(x8), 0);
    check("R1 ovf after reset", int'(of8), 0);

    // R8 random at W=8
    for (int k = 0; k < 3000; k++) begin
      int ra, rb;
      ra = sx(int'($urandom_range(255, 0)), 8);
      rb = sx(int'($urandom_range(255, 0)), 8);
      run8("R8 rand", ra, rb);
    end

    // R8 exhaustive at W=6 (covers R3, R4, R5, R6 at that width)
    for (int ia = -32; ia < 32; ia++) begin
      for (int ib = -32; ib < 32; ib++) begin
        run6(ia, ib);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule